// File: doc/BRIEF.md
# Peripheral Bus Write Sequencer

This block takes a write request of one to four bytes from an on-chip agent and plays it out on an external flash or peripheral bus that is 8 or 16 bits wide. The request never bursts. Each byte, or each halfword on the wide bus, gets its own complete bus cycle. A cycle has two address states, a programmable number of wait states, two data states and a programmable number of recovery states.

A request whose bytes would run past the end of their 32-bit word is refused. For such a request no bus cycle is issued, a sticky error flag is raised and the agent gets its completion pulse at once. The bus width and both wait-state counts are sampled when a request is accepted. The next request is taken only after the final recovery state.

Top module: `pbus_wr_seq`

## Requirements
- R1: A request is taken on a rising clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while no bus cycle is in progress, recovery states included. A request presented while `req_ready` is low has no effect.
- R2: A request is bad when `req_len` is 0 or when `req_addr[1:0] + req_len` exceeds 4. Such a request drives no bus cycle, and in the next cycle both `err_flag` and `req_done` are high.
- R3: `err_flag` stays high until a cycle with `err_clr` = 1 clears it. When a bad request and `err_clr` arrive in the same cycle, the flag stays set.
- R4: With `cfg_wide` = 0 there is one bus cycle per requested byte, in ascending address order. `bus_addr` is the request's upper address bits with the byte offset in bits [1:0]. `bus_data[7:0]` carries request byte lane k = `req_data[8k+7:8k]`, and `bus_data[15:8]` is 0.
- R5: With `cfg_wide` = 1 there is one bus cycle per halfword touched by the request, in ascending order. `bus_addr[0]` is 0, `bus_addr[1]` selects the halfword h, and `bus_data` carries `req_data[16h+15:16h]`.
- R6: Every bus cycle lasts 2 address states, then `cfg_wait`+1 wait states, then 2 data states, then `cfg_rcv`+1 recovery states. All three configuration inputs are sampled when the request is accepted; later changes do not affect a request already in progress.
- R7: `bus_ce_n` is low in the address, wait and data states. `bus_we_n` is low in the wait and data states. `bus_oe_n` is always high. `bus_data_oe` is high exactly when `bus_ce_n` is low.
- R8: `bus_addr` and `bus_data` stay constant from the first address state of a bus cycle to its last recovery state.
- R9: `req_done` is high for one cycle, the cycle right after the last recovery state of the last bus cycle, and `req_ready` is high in that cycle.
- R10: When more bus cycles remain, the next cycle's first address state follows immediately after the previous cycle's last recovery state.
- R11: While idle and during reset, all strobes are high, `bus_addr` and `bus_data` are 0 and `bus_data_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Sequencer idle, can take a request |
| req_addr | input | ADDR_W | Byte address of the first byte |
| req_len | input | 3 | Byte count, 1 to 4 |
| req_data | input | 32 | Write data, byte lane k holds the byte at word offset k |
| req_done | output | 1 | One-cycle completion pulse |
| cfg_wide | input | 1 | 0: 8-bit bus, 1: 16-bit bus |
| cfg_wait | input | WAIT_W | Wait states minus one |
| cfg_rcv | input | RCV_W | Recovery states minus one |
| err_clr | input | 1 | Write 1 to clear the error flag |
| err_flag | output | 1 | Sticky word-crossing error |
| bus_ce_n | output | 1 | Chip enable, active low |
| bus_we_n | output | 1 | Write enable, active low |
| bus_oe_n | output | 1 | Output enable, active low, always high here |
| bus_addr | output | ADDR_W | Bus address |
| bus_data | output | 16 | Bus write data |
| bus_data_oe | output | 1 | Data output driver enable |

## Verification
A bad phase counter shows up at the strobe pins within one bus cycle: a wait or recovery state that is too long or too short moves the edge of `bus_we_n` or `bus_ce_n` by one cycle. A wrong beat count or lane index shows up as an extra or missing bus cycle, or as a wrong address or data word, in the very cycle that bus cycle starts. Errors in the error path appear on `err_flag` and `req_done` one cycle after the request is accepted. Because every port is compared against a model in every cycle, each of these faults is caught in the first cycle it changes a pin.

// File: rtl/pbus_wr_pkg.sv
package pbus_wr_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_ADR1,
      PH_ADR2,
      PH_WAIT,
      PH_DAT1,
      PH_DAT2,
      PH_RCV
   } phase_e;

   localparam int WORD_BYTES = 4;
   localparam int WORD_BITS  = 8 * WORD_BYTES;
   localparam int BUS_BITS   = 16;

endpackage

// File: rtl/pbus_wr_plan.sv
module pbus_wr_plan
   import pbus_wr_pkg::*;
(
   input  logic [1:0] lo,
   input  logic [2:0] len,
   input  logic       wide,
   output logic       bad,
   output logic [2:0] nbeats,
   output logic [1:0] first
);

   logic [3:0] span_end;
   logic [3:0] last_byte;

   always_comb begin
      span_end  = {2'b00, lo} + {1'b0, len};
      last_byte = span_end - 4'd1;
      bad       = (len == 3'd0) || (span_end > 4'(WORD_BYTES));
      if (wide) begin
         first  = {1'b0, lo[1]};
         nbeats = (last_byte[1] != lo[1]) ? 3'd2 : 3'd1;
      end else begin
         first  = lo;
         nbeats = len;
      end
   end

endmodule

// File: rtl/pbus_wr_phase.sv
module pbus_wr_phase
   import pbus_wr_pkg::*;
#(
   parameter int WAIT_W = 3,
   parameter int RCV_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              more,
   input  logic [WAIT_W-1:0] n_wait,
   input  logic [RCV_W-1:0]  n_rcv,
   output phase_e            phase,
   output logic              last_rcv
);

   localparam int CW = (WAIT_W > RCV_W) ? WAIT_W : RCV_W;

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         cnt   <= '0;
      end else begin
         unique case (phase)
            PH_IDLE: if (start) phase <= PH_ADR1;
            PH_ADR1: phase <= PH_ADR2;
            PH_ADR2: begin
               phase <= PH_WAIT;
               cnt   <= '0;
            end
            PH_WAIT: begin
               if (cnt == CW'(n_wait)) phase <= PH_DAT1;
               else                    cnt   <= cnt + 1'b1;
            end
            PH_DAT1: phase <= PH_DAT2;
            PH_DAT2: begin
               phase <= PH_RCV;
               cnt   <= '0;
            end
            PH_RCV: begin
               if (cnt == CW'(n_rcv)) phase <= more ? PH_ADR1 : PH_IDLE;
               else                   cnt   <= cnt + 1'b1;
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   assign last_rcv = (phase == PH_RCV) && (cnt == CW'(n_rcv));

   assert_wait_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_WAIT) |-> (cnt <= CW'(n_wait)));

   assert_rcv_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_RCV) |-> (cnt <= CW'(n_rcv)));

   assert_rcv_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (last_rcv && more) |=> (phase == PH_ADR1));

endmodule

// File: rtl/pbus_wr_lane.sv
module pbus_wr_lane
   import pbus_wr_pkg::*;
(
   input  logic [WORD_BITS-1:0] word,
   input  logic [1:0]           idx,
   input  logic                 wide,
   output logic [BUS_BITS-1:0]  beat
);

   localparam int NHALF = WORD_BITS / BUS_BITS;

   logic [7:0]          bytes [WORD_BYTES];
   logic [BUS_BITS-1:0] halves [NHALF];

   for (genvar b = 0; b < WORD_BYTES; b++) begin : g_byte
      assign bytes[b] = word[8*b +: 8];
   end

   for (genvar h = 0; h < NHALF; h++) begin : g_half
      assign halves[h] = word[BUS_BITS*h +: BUS_BITS];
   end

   assign beat = wide ? halves[idx[0]] : {8'h00, bytes[idx]};

endmodule

// File: rtl/pbus_wr_seq.sv
module pbus_wr_seq
   import pbus_wr_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int WAIT_W = 3,
   parameter int RCV_W  = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   output logic                 req_ready,
   input  logic [ADDR_W-1:0]    req_addr,
   input  logic [2:0]           req_len,
   input  logic [WORD_BITS-1:0] req_data,
   output logic                 req_done,
   input  logic                 cfg_wide,
   input  logic [WAIT_W-1:0]    cfg_wait,
   input  logic [RCV_W-1:0]     cfg_rcv,
   input  logic                 err_clr,
   output logic                 err_flag,
   output logic                 bus_ce_n,
   output logic                 bus_we_n,
   output logic                 bus_oe_n,
   output logic [ADDR_W-1:0]    bus_addr,
   output logic [BUS_BITS-1:0]  bus_data,
   output logic                 bus_data_oe
);

   localparam int HI_W = ADDR_W - 2;

   if (ADDR_W < 4) begin : g_chk_addr
      $error("pbus_wr_seq: ADDR_W must be at least 4");
   end
   if (WAIT_W < 1 || WAIT_W > 4) begin : g_chk_wait
      $error("pbus_wr_seq: WAIT_W must lie in 1..4");
   end
   if (RCV_W < 1 || RCV_W > 3) begin : g_chk_rcv
      $error("pbus_wr_seq: RCV_W must lie in 1..3");
   end

   logic                 bad;
   logic [2:0]           nbeats;
   logic [1:0]           first;
   logic                 accept, go, reject;
   logic                 more, last_rcv;
   phase_e               phase;

   logic [HI_W-1:0]      hi_q;
   logic [WORD_BITS-1:0] data_q;
   logic                 wide_q;
   logic [WAIT_W-1:0]    wait_q;
   logic [RCV_W-1:0]     rcv_q;
   logic [1:0]           idx_q;
   logic [2:0]           left_q;
   logic                 err_q;
   logic                 done_q;
   logic [BUS_BITS-1:0]  lane_word;

   pbus_wr_plan u_plan (
      .lo     (req_addr[1:0]),
      .len    (req_len),
      .wide   (cfg_wide),
      .bad    (bad),
      .nbeats (nbeats),
      .first  (first)
   );

   assign accept = req_valid && req_ready;
   assign go     = accept && !bad;
   assign reject = accept && bad;
   assign more   = (left_q != 3'd1);

   pbus_wr_phase #(
      .WAIT_W (WAIT_W),
      .RCV_W  (RCV_W)
   ) u_phase (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (go),
      .more     (more),
      .n_wait   (wait_q),
      .n_rcv    (rcv_q),
      .phase    (phase),
      .last_rcv (last_rcv)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q   <= '0;
         data_q <= '0;
         wide_q <= 1'b0;
         wait_q <= '0;
         rcv_q  <= '0;
         idx_q  <= '0;
         left_q <= '0;
         err_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         err_q  <= reject | (err_q & ~err_clr);
         if (go) begin
            hi_q   <= req_addr[ADDR_W-1:2];
            data_q <= req_data;
            wide_q <= cfg_wide;
            wait_q <= cfg_wait;
            rcv_q  <= cfg_rcv;
            idx_q  <= first;
            left_q <= nbeats;
         end else if (last_rcv) begin
            if (more) begin
               left_q <= left_q - 3'd1;
               idx_q  <= idx_q + 2'd1;
            end else begin
               done_q <= 1'b1;
            end
         end
         if (reject) done_q <= 1'b1;
      end
   end

   pbus_wr_lane u_lane (
      .word (data_q),
      .idx  (idx_q),
      .wide (wide_q),
      .beat (lane_word)
   );

   logic drive, strobe_we, active;

   always_comb begin
      active    = (phase != PH_IDLE);
      drive     = (phase inside {PH_ADR1, PH_ADR2, PH_WAIT, PH_DAT1, PH_DAT2});
      strobe_we = (phase inside {PH_WAIT, PH_DAT1, PH_DAT2});
      if (!active)     bus_addr = '0;
      else if (wide_q) bus_addr = {hi_q, idx_q[0], 1'b0};
      else             bus_addr = {hi_q, idx_q};
      bus_data = active ? lane_word : '0;
   end

   assign req_ready   = !active;
   assign req_done    = done_q;
   assign err_flag    = err_q;
   assign bus_ce_n    = !drive;
   assign bus_we_n    = !strobe_we;
   assign bus_oe_n    = 1'b1;
   assign bus_data_oe = drive;

   assert_ready_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (bus_ce_n && bus_we_n));

   assert_reject_R2: assert property (@(posedge clk) disable iff (!rst_n)
      reject |=> (bus_ce_n && err_flag && req_done));

   assert_err_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (err_flag && !err_clr) |=> err_flag);

   assert_addr_before_we_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_we_n) |-> ($past(!bus_ce_n && bus_we_n) && $past(!bus_ce_n && bus_we_n, 2)));

   assert_we_inside_ce_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_we_n |-> !bus_ce_n);

   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_ce_n && $past(!bus_ce_n)) |-> ($stable(bus_addr) && $stable(bus_data)));

   assert_done_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
      req_done |-> req_ready);

endmodule

// File: tb/test_pbus_wr_seq.sv
`timescale 1ns/1ps
module test_pbus_wr_seq;

   localparam int AW = 24;
   localparam int WW = 3;
   localparam int RW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [2:0]    req_len = '0;
   logic [31:0]   req_data = '0;
   logic          cfg_wide = 1'b0;
   logic [WW-1:0] cfg_wait = '0;
   logic [RW-1:0] cfg_rcv = '0;
   logic          err_clr = 1'b0;
   logic          req_ready, req_done, err_flag;
   logic          bus_ce_n, bus_we_n, bus_oe_n, bus_data_oe;
   logic [AW-1:0] bus_addr;
   logic [15:0]   bus_data;

   always #2.5 clk = ~clk;

   pbus_wr_seq #(.ADDR_W(AW), .WAIT_W(WW), .RCV_W(RW)) i_pbus_wr_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_len(req_len), .req_data(req_data), .req_done(req_done),
      .cfg_wide(cfg_wide), .cfg_wait(cfg_wait), .cfg_rcv(cfg_rcv), .err_clr(err_clr),
      .err_flag(err_flag), .bus_ce_n(bus_ce_n), .bus_we_n(bus_we_n), .bus_oe_n(bus_oe_n),
      .bus_addr(bus_addr), .bus_data(bus_data), .bus_data_oe(bus_data_oe)
   );

   typedef struct packed {
      logic          ce;
      logic          we;
      logic          doe;
      logic          done;
      logic          rdy;
      logic [AW-1:0] a;
      logic [15:0]   d;
   } exp_t;

   exp_t q[$];
   exp_t cur;
   logic err_m;
   int   checks = 0;
   int   errors = 0;
   bit   finished = 1'b0;

   function automatic exp_t idle_rec(logic done);
      exp_t e;
      e.ce = 1'b1; e.we = 1'b1; e.doe = 1'b0; e.done = done; e.rdy = 1'b1;
      e.a = '0; e.d = '0;
      return e;
   endfunction

   // one bus cycle: 2 address, w+1 wait, 2 data, r+1 recovery states
   function automatic void push_beat(logic [AW-1:0] a, logic [15:0] d, int w, int r);
      int total = 2 + (w + 1) + 2 + (r + 1);
      for (int c = 0; c < total; c++) begin
         exp_t e;
         e.ce   = (c < 5 + w) ? 1'b0 : 1'b1;
         e.we   = (c >= 2 && c < 5 + w) ? 1'b0 : 1'b1;
         e.doe  = ~e.ce;
         e.done = 1'b0;
         e.rdy  = 1'b0;
         e.a    = a;
         e.d    = d;
         q.push_back(e);
      end
   endfunction

   function automatic bit is_bad(logic [AW-1:0] a, logic [2:0] len);
      return (len == 0) || (int'(a[1:0]) + int'(len) > 4);
   endfunction

   function automatic void push_req(logic [AW-1:0] a, logic [2:0] len, logic [31:0] d,
                                    logic wide, int w, int r);
      int lo = int'(a[1:0]);
      int last = lo + int'(len) - 1;
      if (!is_bad(a, len)) begin
         if (!wide) begin
            for (int i = lo; i <= last; i++)
               push_beat({a[AW-1:2], 2'(i)}, {8'h00, d[8*i +: 8]}, w, r);
         end else begin
            for (int h = lo / 2; h <= last / 2; h++)
               push_beat({a[AW-1:2], 1'(h), 1'b0}, d[16*h +: 16], w, r);
         end
      end
      q.push_back(idle_rec(1'b1));
   endfunction

   // reference model, advanced on every rising edge
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q.delete();
         cur   = idle_rec(1'b0);
         err_m = 1'b0;
      end else begin
         bit acc;
         acc = req_valid && cur.rdy;
         if (q.size() > 0) void'(q.pop_front());
         if (acc) push_req(req_addr, req_len, req_data, cfg_wide, int'(cfg_wait), int'(cfg_rcv));
         if (acc && is_bad(req_addr, req_len)) err_m = 1'b1;
         else if (err_clr)                     err_m = 1'b0;
         cur = (q.size() > 0) ? q[0] : idle_rec(1'b0);
      end
   end

   function automatic void chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endfunction

   always @(negedge clk) begin
      if (!finished) begin
         chk("R7 chip enable (R6 phase lengths, R10 back-to-back beats)", 32'(bus_ce_n), 32'(cur.ce));
         chk("R7 write enable (R6 phase lengths)", 32'(bus_we_n), 32'(cur.we));
         chk("R7 output enable", 32'(bus_oe_n), 32'd1);
         chk("R7 data drive", 32'(bus_data_oe), 32'(cur.doe));
         if (cur.ce && cur.rdy) begin
            chk("R11 idle address", 32'(bus_addr), 32'(cur.a));
            chk("R11 idle data", 32'(bus_data), 32'(cur.d));
         end else begin
            chk("R4 R5 R8 bus address", 32'(bus_addr), 32'(cur.a));
            chk("R4 R5 R8 bus data", 32'(bus_data), 32'(cur.d));
         end
         chk("R9 done pulse", 32'(req_done), 32'(cur.done));
         chk("R1 ready", 32'(req_ready), 32'(cur.rdy));
         chk("R2 R3 error flag", 32'(err_flag), 32'(err_m));
      end
   end

   task automatic send(logic [AW-1:0] a, logic [2:0] len, logic [31:0] d,
                       logic wide, logic [WW-1:0] w, logic [RW-1:0] r);
      while (!cur.rdy) @(negedge clk);
      req_addr = a; req_len = len; req_data = d;
      cfg_wide = wide; cfg_wait = w; cfg_rcv = r;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      // scramble inputs while busy: R6 latching, R1 ignoring
      cfg_wide = ~wide; cfg_wait = ~w; cfg_rcv = ~r;
      req_addr = AW'($urandom); req_len = 3'($urandom); req_data = $urandom;
   endtask

   task automatic drain();
      while (!(cur.rdy && q.size() == 0)) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);   // R11 reset state checked here
      rst_n = 1'b1;
      @(negedge clk);
      send(24'h000100, 3'd4, 32'hA1B2C3D4, 1'b0, 3'd0, 2'd0);   // R4 aligned word, 8-bit
      send(24'h000201, 3'd3, 32'h11223344, 1'b0, 3'd7, 2'd3);   // R4 R6 longest phases
      send(24'h000300, 3'd4, 32'hCAFEF00D, 1'b1, 3'd2, 2'd1);   // R5 two halfwords
      send(24'h000401, 3'd2, 32'h55667788, 1'b1, 3'd0, 2'd0);   // R5 straddles halfwords
      send(24'h000503, 3'd1, 32'h99AABBCC, 1'b1, 3'd1, 2'd2);   // R5 upper halfword only
      send(24'h000602, 3'd3, 32'h01020304, 1'b0, 3'd0, 2'd0);   // R2 crossing
      send(24'h000700, 3'd0, 32'h01020304, 1'b0, 3'd0, 2'd0);   // R2 zero length
      send(24'h000800, 3'd4, 32'h0BADBEEF, 1'b0, 3'd1, 2'd0);   // R3 flag stays
      drain();
      err_clr = 1'b1;                                          // R3 clear
      @(negedge clk);
      err_clr = 1'b0;
      @(negedge clk);
      err_clr = 1'b1;                                          // R3 set beats clear
      send(24'h000903, 3'd2, 32'h0, 1'b1, 3'd0, 2'd0);
      err_clr = 1'b0;
      drain();
      // R1: valid held high through busy periods
      req_addr = 24'h000A00; req_len = 3'd2; req_data = 32'h12345678;
      cfg_wide = 1'b0; cfg_wait = 3'd1; cfg_rcv = 2'd1;
      req_valid = 1'b1;
      repeat (60) @(negedge clk);
      req_valid = 1'b0;
      drain();
      for (int n = 0; n < 60; n++) begin
         err_clr = ($urandom_range(0, 7) == 0);
         send(AW'($urandom), 3'($urandom_range(0, 5)), $urandom, 1'($urandom),
              WW'($urandom), RW'($urandom));
         err_clr = 1'b0;
      end
      drain();
      finish_run();
   end

endmodule